// File: doc/BRIEF.md
# Interrupt entry sequencer

This block carries out the hardware part of taking an interrupt on a 16-bit segmented processor. At an instruction boundary it looks at the pending requests and at the current flags. These requests are a divide fault, an overflow-check trap, a non-maskable request, a maskable request with its own type number, and the single-step condition. It picks at most one request and captures the flags, code segment, instruction pointer, stack segment and stack pointer.

It then writes three words onto the stack through a single 16-bit memory port, clears the interrupt-enable and trap flags at fixed points in that sequence, and reads the new instruction pointer and code segment from the vector table in low memory. A one-cycle completion pulse marks the point where the new segment, pointer, flags and stack pointer are valid on the outputs. The memory port is word-wide. A read returns its data on `mem_rdata` in the cycle after the request.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy`, `done` and `mem_req` are low.
- R2: When several requests are accepted together, the chosen type follows this fixed priority: divide fault (type 0), then overflow check (type 4), then non-maskable (type 2), then maskable (type from `intr_type`), then single-step (type 1). The chosen type appears on `vec_type`.
- R3: A maskable request is taken only when flag bit 9 (interrupt enable) is 1. An overflow-check request is taken only when flag bit 11 (overflow) is 1. Single-step is raised only when flag bit 8 (trap) is 1. A request that fails its rule starts no sequence, and a lower-priority request is considered in its place.
- R4: Requests are sampled only in a cycle where `boundary` is high and the block is idle. Requests seen while `boundary` is low, or while a sequence runs, start nothing.
- R5: In the three cycles after acceptance the block writes three words, in this order: the captured flags, the code segment, and the instruction pointer. Their byte addresses are SS*16 + SP-2, SS*16 + SP-4 and SS*16 + SP-6.
- R6: The interrupt-enable flag (bit 9) reads 0 on `flags_out` from the second cycle after acceptance. The trap flag (bit 8) still holds its captured value in that cycle and reads 0 from the third cycle. The final flags equal the captured flags with bits 9 and 8 cleared.
- R7: For type n the new instruction pointer is the word read at byte address 4n, and the new code segment is the word read at 4n+2.
- R8: `busy` is high for exactly seven cycles after acceptance. `done` is high only in the seventh of these cycles, for one cycle.
- R9: `sp_out` drops by 2 at each of the three writes, modulo 2^16, and ends at the captured SP minus 6.
- R10: Flags, segments and pointers are captured at acceptance. Changing the inputs during the sequence does not change the stored words or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction boundary; requests are sampled here |
| div_err | input | 1 | Divide fault request |
| ovf_chk | input | 1 | Overflow-check instruction request |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request |
| intr_type | input | 8 | Type number of the maskable request |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | 20 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: results valid |
| vec_type | output | 8 | Type number being serviced |
| flags_out | output | 16 | Working flags word |
| cs_out | output | 16 | Code segment (new value at `done`) |
| ip_out | output | 16 | Instruction pointer (new value at `done`) |
| sp_out | output | 16 | Working stack pointer |

## Verification
An accepted request raises `busy` after the clock edge that samples it. The flags write is presented in that first cycle, and the code segment and instruction pointer writes in the next two. IF is clear from cycle two, TF from cycle three, and all results with `done` are due in cycle seven. The bench drives inputs on the falling edge and counts falling edges from the sampling edge. It checks each result in exactly its due cycle, and checks `busy` and `done` in every cycle in between. For rejected requests it checks one cycle after the sampling edge that `busy` stayed low and that no write occurred.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   // flag word bit positions used by acceptance and clearing rules
   localparam int FLAG_TF = 8;
   localparam int FLAG_IF = 9;
   localparam int FLAG_OF = 11;

   // number of request sources seen by the arbiter
   localparam int NUM_SRC = 5;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PUSH_FL  = 3'd1,
      ST_PUSH_CS  = 3'd2,
      ST_PUSH_IP  = 3'd3,
      ST_RD_OFS   = 3'd4,
      ST_RD_SEG   = 3'd5,
      ST_LOAD_SEG = 3'd6,
      ST_DONE     = 3'd7
   } seq_state_t;
endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb
   import irq_entry_pkg::*;
#(
   parameter int TYPE_W = 8,
   parameter logic [TYPE_W-1:0] T_DIV  = 0,
   parameter logic [TYPE_W-1:0] T_STEP = 1,
   parameter logic [TYPE_W-1:0] T_NMI  = 2,
   parameter logic [TYPE_W-1:0] T_OVF  = 4
) (
   input  logic              f_if,
   input  logic              f_tf,
   input  logic              f_of,
   input  logic              div_err,
   input  logic              ovf_chk,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [TYPE_W-1:0] intr_type,
   output logic              take,
   output logic [TYPE_W-1:0] take_type
);
   // slot index is priority: slot 0 wins
   logic [NUM_SRC-1:0] live;
   logic [TYPE_W-1:0]  tcode [NUM_SRC];

   assign live[0]  = div_err;
   assign tcode[0] = T_DIV;
   assign live[1]  = ovf_chk & f_of;
   assign tcode[1] = T_OVF;
   assign live[2]  = nmi_req;
   assign tcode[2] = T_NMI;
   assign live[3]  = intr_req & f_if;
   assign tcode[3] = intr_type;
   assign live[4]  = f_tf;
   assign tcode[4] = T_STEP;

   always_comb begin
      take_type = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (live[i]) take_type = tcode[i];
      end
   end

   assign take = |live;
endmodule

// File: rtl/irq_stack_addr.sv
module irq_stack_addr #(
   parameter int ADDR_W    = 20,
   parameter int WORD_W    = 16,
   parameter int SEG_SHIFT = 4,
   parameter bit FLAT      = 1'b0
) (
   input  logic [WORD_W-1:0] seg,
   input  logic [WORD_W-1:0] ofs,
   output logic [ADDR_W-1:0] phys
);
   generate
      if (FLAT) begin : g_flat
         assign phys = ADDR_W'(ofs);
      end else begin : g_seg
         if (ADDR_W < WORD_W + SEG_SHIFT) begin : g_bad_w
            $error("irq_stack_addr: ADDR_W too narrow for segment shift");
         end
         localparam int SW = WORD_W + SEG_SHIFT;
         logic [SW-1:0] seg_base;
         assign seg_base = {seg, {SEG_SHIFT{1'b0}}};
         assign phys = ADDR_W'(seg_base) + ADDR_W'(ofs);
      end
   endgenerate
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_entry_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int TYPE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              take,
   input  logic [TYPE_W-1:0] take_type,
   input  logic [WORD_W-1:0] flags_in,
   input  logic [WORD_W-1:0] cs_in,
   input  logic [WORD_W-1:0] ip_in,
   input  logic [WORD_W-1:0] sp_in,
   input  logic [WORD_W-1:0] ss_in,
   input  logic [WORD_W-1:0] mem_rdata,
   output seq_state_t        state,
   output logic [WORD_W-1:0] flags_r,
   output logic [WORD_W-1:0] cs_r,
   output logic [WORD_W-1:0] ip_r,
   output logic [WORD_W-1:0] sp_r,
   output logic [WORD_W-1:0] ss_r,
   output logic [TYPE_W-1:0] type_r,
   output logic [WORD_W-1:0] push_ofs,
   output logic [WORD_W-1:0] push_data
);
   assign push_ofs = sp_r - WORD_W'(2);

   always_comb begin
      unique case (state)
         ST_PUSH_FL: push_data = flags_r;
         ST_PUSH_CS: push_data = cs_r;
         ST_PUSH_IP: push_data = ip_r;
         default:    push_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         flags_r <= '0;
         cs_r    <= '0;
         ip_r    <= '0;
         sp_r    <= '0;
         ss_r    <= '0;
         type_r  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (boundary && take) begin
                  state   <= ST_PUSH_FL;
                  type_r  <= take_type;
                  flags_r <= flags_in;
                  cs_r    <= cs_in;
                  ip_r    <= ip_in;
                  sp_r    <= sp_in;
                  ss_r    <= ss_in;
               end
            end
            ST_PUSH_FL: begin
               sp_r             <= push_ofs;
               flags_r[FLAG_IF] <= 1'b0;
               state            <= ST_PUSH_CS;
            end
            ST_PUSH_CS: begin
               sp_r             <= push_ofs;
               flags_r[FLAG_TF] <= 1'b0;
               state            <= ST_PUSH_IP;
            end
            ST_PUSH_IP: begin
               sp_r  <= push_ofs;
               state <= ST_RD_OFS;
            end
            ST_RD_OFS: state <= ST_RD_SEG;
            ST_RD_SEG: begin
               ip_r  <= mem_rdata;
               state <= ST_LOAD_SEG;
            end
            ST_LOAD_SEG: begin
               cs_r  <= mem_rdata;
               state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int WORD_W    = 16,
   parameter int TYPE_W    = 8,
   parameter int SEG_SHIFT = 4,
   parameter bit FLAT_STACK = 1'b0,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              div_err,
   input  logic              ovf_chk,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [TYPE_W-1:0] intr_type,
   input  logic [WORD_W-1:0] flags_in,
   input  logic [WORD_W-1:0] cs_in,
   input  logic [WORD_W-1:0] ip_in,
   input  logic [WORD_W-1:0] sp_in,
   input  logic [WORD_W-1:0] ss_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [TYPE_W-1:0] vec_type,
   output logic [WORD_W-1:0] flags_out,
   output logic [WORD_W-1:0] cs_out,
   output logic [WORD_W-1:0] ip_out,
   output logic [WORD_W-1:0] sp_out
);
   localparam int VEC_SPAN = TYPE_W + 2;

   generate
      if (WORD_W <= FLAG_OF) begin : g_bad_word
         $error("irq_entry_seq: WORD_W must hold the overflow flag bit");
      end
      if (ADDR_W < VEC_SPAN) begin : g_bad_vec
         $error("irq_entry_seq: ADDR_W cannot reach the vector table");
      end
   endgenerate

   logic              take;
   logic [TYPE_W-1:0] take_type;
   seq_state_t        state;
   logic [WORD_W-1:0] ss_r;
   logic [WORD_W-1:0] push_ofs;
   logic [WORD_W-1:0] push_data;
   logic [ADDR_W-1:0] stack_addr;
   logic [ADDR_W-1:0] vec_addr;
   logic              in_push;
   logic              in_read;

   irq_req_arb #(.TYPE_W(TYPE_W)) arb_i (
      .f_if      (flags_in[FLAG_IF]),
      .f_tf      (flags_in[FLAG_TF]),
      .f_of      (flags_in[FLAG_OF]),
      .div_err   (div_err),
      .ovf_chk   (ovf_chk),
      .nmi_req   (nmi_req),
      .intr_req  (intr_req),
      .intr_type (intr_type),
      .take      (take),
      .take_type (take_type)
   );

   irq_seq_ctrl #(.WORD_W(WORD_W), .TYPE_W(TYPE_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .take      (take),
      .take_type (take_type),
      .flags_in  (flags_in),
      .cs_in     (cs_in),
      .ip_in     (ip_in),
      .sp_in     (sp_in),
      .ss_in     (ss_in),
      .mem_rdata (mem_rdata),
      .state     (state),
      .flags_r   (flags_out),
      .cs_r      (cs_out),
      .ip_r      (ip_out),
      .sp_r      (sp_out),
      .ss_r      (ss_r),
      .type_r    (vec_type),
      .push_ofs  (push_ofs),
      .push_data (push_data)
   );

   irq_stack_addr #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .FLAT(FLAT_STACK)
   ) stk_i (
      .seg  (ss_r),
      .ofs  (push_ofs),
      .phys (stack_addr)
   );

   // entry n occupies four bytes: offset word first, segment word second
   assign vec_addr = VEC_BASE + (ADDR_W'(vec_type) << 2)
                   + ((state == ST_RD_SEG) ? ADDR_W'(2) : ADDR_W'(0));

   assign in_push = (state == ST_PUSH_FL) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
   assign in_read = (state == ST_RD_OFS) || (state == ST_RD_SEG);

   assign mem_req   = in_push || in_read;
   assign mem_we    = in_push;
   assign mem_addr  = in_push ? stack_addr : (in_read ? vec_addr : '0);
   assign mem_wdata = push_data;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boundary,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              flag_if,
   input logic [WORD_W-1:0] sp_out
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   p_start_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(boundary));

   p_if_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !flag_if);

   p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_sp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> (sp_out == $past(sp_out) - WORD_W'(2)));
endmodule

bind irq_entry_seq irq_entry_chk #(.WORD_W(WORD_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .boundary (boundary),
   .busy     (busy),
   .done     (done),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .flag_if  (flags_out[irq_entry_pkg::FLAG_IF]),
   .sp_out   (sp_out)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
   localparam int CLK_T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary = 1'b0;
   logic        div_err = 1'b0, ovf_chk = 1'b0, nmi_req = 1'b0, intr_req = 1'b0;
   logic [7:0]  intr_type = '0;
   logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, sp_in = '0, ss_in = '0;
   logic        mem_req, mem_we;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        busy, done;
   logic [7:0]  vec_type;
   logic [15:0] flags_out, cs_out, ip_out, sp_out;

   int n_chk = 0;
   int n_fail = 0;
   int wr_cnt = 0;
   logic [19:0] wa_log [3];
   logic [15:0] wd_log [3];

   always #(CLK_T/2) clk = ~clk;

   irq_entry_seq dut_i (
      .clk(clk), .rst_n(rst_n), .boundary(boundary),
      .div_err(div_err), .ovf_chk(ovf_chk), .nmi_req(nmi_req), .intr_req(intr_req),
      .intr_type(intr_type), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
      .sp_in(sp_in), .ss_in(ss_in), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .vec_type(vec_type), .flags_out(flags_out),
      .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out)
   );

   // vector table contents: a fixed function of the byte address
   function automatic logic [15:0] vec_word(input logic [19:0] a);
      return 16'(a * 20'd37 + 20'h1357);
   endfunction

   // memory model: word port, read data one cycle after request
   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         if (wr_cnt < 3) begin
            wa_log[wr_cnt] <= mem_addr;
            wd_log[wr_cnt] <= mem_wdata;
         end
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_req && !mem_we) mem_rdata <= vec_word(mem_addr);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected {take, type} from the acceptance and priority rules (R2, R3)
   function automatic logic [8:0] pick(input logic dv, ov, nm, it, input logic [7:0] ity,
                                       input logic [15:0] fl);
      if (dv) return {1'b1, 8'd0};
      if (ov && fl[11]) return {1'b1, 8'd4};
      if (nm) return {1'b1, 8'd2};
      if (it && fl[9]) return {1'b1, ity};
      if (fl[8]) return {1'b1, 8'd1};
      return 9'd0;
   endfunction

   function automatic logic [19:0] phys(input logic [15:0] ss, input logic [15:0] ofs);
      return {ss, 4'h0} + {4'h0, ofs};
   endfunction

   task automatic run_case(input logic dv, ov, nm, it, input logic [7:0] ity,
                           input logic [15:0] fl, cs, ip, sp, ss, input logic poke);
      logic [8:0] e;
      e = pick(dv, ov, nm, it, ity, fl);
      @(negedge clk);
      div_err = dv; ovf_chk = ov; nmi_req = nm; intr_req = it; intr_type = ity;
      flags_in = fl; cs_in = cs; ip_in = ip; sp_in = sp; ss_in = ss;
      boundary = 1'b1; wr_cnt = 0;
      @(negedge clk);
      // cycle 1: scramble inputs to show capture at acceptance (R10)
      boundary = 1'b0;
      div_err = 1'b0; ovf_chk = 1'b0; nmi_req = 1'b0; intr_req = 1'b0;
      flags_in = ~fl & 16'hF4FF; cs_in = ~cs; ip_in = ~ip; sp_in = ~sp; ss_in = ~ss;
      if (!e[8]) begin
         chk("R3 rejected request leaves busy low", {31'd0, busy}, 32'd0);
         chk("R3 rejected request makes no write", wr_cnt, 0);
         return;
      end
      chk("R8 busy in cycle 1", {31'd0, busy}, 32'd1);
      chk("R10 flags captured", {16'd0, flags_out}, {16'd0, fl});
      if (poke) begin
         nmi_req = 1'b1; boundary = 1'b1;
      end
      @(negedge clk);
      chk("R6 IF clear in cycle 2", {31'd0, flags_out[9]}, 32'd0);
      chk("R6 TF held in cycle 2", {31'd0, flags_out[8]}, {31'd0, fl[8]});
      @(negedge clk);
      chk("R6 TF clear in cycle 3", {31'd0, flags_out[8]}, 32'd0);
      nmi_req = 1'b0; boundary = 1'b0;
      for (int c = 4; c <= 7; c++) begin
         @(negedge clk);
         chk("R8 busy during sequence", {31'd0, busy}, 32'd1);
         chk("R8 done timing", {31'd0, done}, {31'd0, c == 7});
      end
      chk("R2 serviced type", {24'd0, vec_type}, {24'd0, e[7:0]});
      chk("R7 new IP from 4n", {16'd0, ip_out}, {16'd0, vec_word({10'd0, e[7:0], 2'b00})});
      chk("R7 new CS from 4n+2", {16'd0, cs_out}, {16'd0, vec_word({10'd0, e[7:0], 2'b10})});
      chk("R9 final SP", {16'd0, sp_out}, {16'd0, 16'(sp - 16'd6)});
      chk("R6 final flags", {16'd0, flags_out}, {16'd0, fl & 16'hFCFF});
      chk("R5 write count", wr_cnt, 3);
      chk("R5 flags address", {12'd0, wa_log[0]}, {12'd0, phys(ss, 16'(sp - 16'd2))});
      chk("R5 CS address", {12'd0, wa_log[1]}, {12'd0, phys(ss, 16'(sp - 16'd4))});
      chk("R5 IP address", {12'd0, wa_log[2]}, {12'd0, phys(ss, 16'(sp - 16'd6))});
      chk("R5 flags word", {16'd0, wd_log[0]}, {16'd0, fl});
      chk("R10 CS word", {16'd0, wd_log[1]}, {16'd0, cs});
      chk("R10 IP word", {16'd0, wd_log[2]}, {16'd0, ip});
      @(negedge clk);
      chk("R1 idle after done", {30'd0, busy, done}, 32'd0);
      @(negedge clk);
      chk("R4 no restart from request seen while busy", {31'd0, busy}, 32'd0);
      flags_in = 16'h0000;
   endtask

   initial begin
      #(CLK_T * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 reset busy/done/mem_req", {29'd0, busy, done, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {29'd0, busy, done, mem_req}, 32'd0);

      // R4: requests with boundary low
      nmi_req = 1'b1; div_err = 1'b1;
      repeat (3) @(negedge clk);
      chk("R4 no start without boundary", {31'd0, busy}, 32'd0);
      nmi_req = 1'b0; div_err = 1'b0;

      // R2 priority corners
      run_case(1, 1, 1, 1, 8'h40, 16'h0B00, 16'h1111, 16'h2222, 16'h0100, 16'h0300, 0);
      run_case(0, 1, 1, 1, 8'h40, 16'h0A00, 16'h1234, 16'h5678, 16'h0200, 16'h0000, 0);
      run_case(0, 1, 1, 1, 8'h40, 16'h0200, 16'hAAAA, 16'h5555, 16'h8000, 16'h1000, 0);
      run_case(0, 0, 0, 1, 8'hFF, 16'h0300, 16'hBEEF, 16'hCAFE, 16'h4000, 16'h2000, 0);
      run_case(0, 0, 0, 0, 8'h00, 16'h0100, 16'h0001, 16'h0002, 16'h0010, 16'h0040, 0);
      // R3 rejections
      run_case(0, 0, 0, 1, 8'h21, 16'h0000, 16'h0001, 16'h0002, 16'h0010, 16'h0040, 0);
      run_case(0, 1, 0, 0, 8'h21, 16'h0200, 16'h0001, 16'h0002, 16'h0010, 16'h0040, 0);
      // R9 wrap of stack pointer, R4 request during busy
      run_case(0, 0, 1, 0, 8'h00, 16'h0000, 16'h7000, 16'h0123, 16'h0002, 16'hF000, 1);
      run_case(1, 0, 0, 0, 8'h00, 16'hFFFF, 16'h7001, 16'h0124, 16'h0000, 16'hFFFF, 1);

      for (int k = 0; k < 60; k++) begin
         logic [3:0] r;
         r = 4'($urandom);
         run_case(r[0] & r[1], r[2], r[3] & r[0], 1'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 1'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule